// File: doc/BRIEF.md
# Serial multiplier by a fixed signed-digit coefficient

The block multiplies a two's complement operand, presented one bit per clock starting with the least significant bit, by a coefficient fixed at build time. The coefficient is given as canonic signed digits: each digit is -1, 0 or +1, and no two neighbouring digits are nonzero. The product leaves the block serially, also least significant bit first, as a full-width two's complement word of `DATA_W + DIG_N` bits. The product is exact: nothing is rounded and no bit is dropped.

Each nonzero digit owns one full-adder cell. A zero digit's cell is only a delay stage on the sum chain. The block never subtracts. For a +1 digit the cell uses the operand with its sign bit flipped. For a -1 digit it flips every bit except the sign bit. The arithmetic error that these flips leave is repaid by a correction constant computed at elaboration. Its low part (a 1 at the position of each -1 digit) presets that cell's carry flip-flop on the first bit. Its high part enters serially at the sum input of the top cell. An internal sequencer derives the first-bit, sign-bit and operand-window strobes from a single start strobe.

A word is started by raising `start_i` for one cycle, in the same cycle as operand bit 0. Operand bit t is then presented t cycles later. A new word may start no sooner than `DATA_W + DIG_N` cycles after the previous one.

Top module: `csd_serial_mul`

## Requirements
- R1: While reset is asserted, and while no word is in flight (even if `x_i` toggles), `prod_o`, `prod_vld_o` and `prod_sop_o` are 0.
- R2: After a cycle with `start_i`=1, `prod_vld_o` is 1 for exactly `DATA_W + DIG_N` consecutive cycles, starting one cycle after the start cycle.
- R3: `prod_sop_o` is 1 only in the first valid cycle of each product, which carries bit 0.
- R4: With a coefficient whose nonzero digits are all +1, the product equals operand times coefficient for every operand.
- R5: With coefficients that contain -1 digits, including a -1 in the most significant digit position, the product is exact for every operand, including the most negative operand -2^(DATA_W-1).
- R6: `x_i` is sampled only in the `DATA_W` cycles that begin with the start cycle. Its value in every other cycle has no effect on the product.
- R7: In the k-th valid cycle (k = 0 first), `prod_o` carries bit k of the two's complement product of the signed `DATA_W`-bit operand and the coefficient, taken modulo 2^(DATA_W+DIG_N).
- R8: A word started exactly `DATA_W + DIG_N` cycles after the previous one gives an exact product, with nothing carried over from the earlier word. A start while a word is still in flight is a usage error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Marks the cycle that carries operand bit 0 |
| x_i | input | 1 | Serial operand, LSB first |
| prod_o | output | 1 | Serial product bit, LSB first |
| prod_vld_o | output | 1 | Product bit valid |
| prod_sop_o | output | 1 | First (LSB) product bit |

## Verification
The hardest case to reach from the ports is a word starting in the very cycle after the previous product's last bit was computed. In that case the first-bit preset must override carries and sums that are still live in every cell, and no leftover may leak into the new word. The bench spaces about a third of the words at exactly the minimum distance, and fills every cycle outside the operand window with random bits, so any leakage or late sampling corrupts a product. Three coefficient variants are swept over all 256 operands: mixed signs with a -1 top digit, a zero top digit, and all-positive digits. Together they cover the inverted-input paths, the carry presets and the pass-through cell that carries the injected constant.

// File: rtl/csd_mul_pkg.sv
package csd_mul_pkg;

  // High part of the correction: minus the sign-position ones of every nonzero digit,
  // modulo 2^(n+m). Result is valid for n+m <= 63.
  function automatic logic [63:0] hi_corr(input int n, input int m, input logic [63:0] nz);
    logic [63:0] acc;
    logic [63:0] msk;
    acc = '0;
    for (int k = 0; k < m; k++) begin
      if (nz[k]) acc = acc + (64'd1 << (n - 1 + k));
    end
    msk = (64'd1 << (n + m)) - 64'd1;
    return (~acc + 64'd1) & msk;
  endfunction

endpackage

// File: rtl/csd_mul_seq.sv
module csd_mul_seq #(
  parameter int DATA_W = 8,
  parameter int PW     = 14,
  parameter int CW     = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          act_o,
  output logic          first_o,
  output logic          win_o,
  output logic          msb_o,
  output logic [CW-1:0] cnt_o
);

  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cur;

  assign cur     = start_i ? '0 : cnt_q;
  assign act_o   = start_i | run_q;
  assign first_o = start_i;
  assign win_o   = act_o && (cur < CW'(DATA_W));
  assign msb_o   = act_o && (cur == CW'(DATA_W - 1));
  assign cnt_o   = cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= CW'(1);
    end else if (run_q) begin
      cnt_q <= cnt_q + CW'(1);
      run_q <= (cnt_q != CW'(PW - 1));
    end
  end

  AST_START_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !run_q); // R8
  AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < CW'(PW))); // R2
  AST_MSB_IN_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msb_o |-> win_o); // R6

endmodule

// File: rtl/csd_mul_cell.sv
module csd_mul_cell #(
  parameter bit NZ  = 1'b1,
  parameter bit NEG = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic first_i,
  input  logic win_i,
  input  logic msb_i,
  input  logic x_i,
  input  logic s_i,
  output logic sum_o,
  output logic sum_q_o
);

  logic sum_q;

  if (NZ) begin : g_fa
    logic c_q, c_eff, pp, c_nx;
    // +1: flip sign bit only; -1: flip all but sign bit
    assign pp    = win_i & (x_i ^ (NEG ? ~msb_i : msb_i));
    assign c_eff = first_i ? NEG : c_q;
    assign sum_o = pp ^ s_i ^ c_eff;
    assign c_nx  = (pp & s_i) | (pp & c_eff) | (s_i & c_eff);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    c_q <= 1'b0;
      else if (act_i) c_q <= c_nx;
    end

    AST_CARRY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !act_i |=> $stable(c_q)); // R6
  end else begin : g_dly
    logic unused_in;
    assign unused_in = ^{first_i, win_i, msb_i, x_i};
    assign sum_o     = s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= 1'b0;
    else if (act_i) sum_q <= sum_o;
  end

  assign sum_q_o = sum_q;

endmodule

// File: rtl/csd_serial_mul.sv
module csd_serial_mul #(
  parameter int               DATA_W  = 8,
  parameter int               DIG_N   = 6,
  parameter logic [DIG_N-1:0] DIG_NZ  = 6'b100101,
  parameter logic [DIG_N-1:0] DIG_NEG = 6'b100001
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic x_i,
  output logic prod_o,
  output logic prod_vld_o,
  output logic prod_sop_o
);

  localparam int          PW      = DATA_W + DIG_N;
  localparam int          CW      = $clog2(PW + 1);
  localparam logic [63:0] HI_FULL = csd_mul_pkg::hi_corr(DATA_W, DIG_N, 64'(DIG_NZ));
  localparam logic [PW-1:0] HI_K  = HI_FULL[PW-1:0];

  logic          act, first, win, msb;
  logic [CW-1:0] cnt;
  logic [CW:0]   inj_idx;
  logic [PW-1:0] hi_sh;
  logic          inj;
  logic [DIG_N-1:0] s_in, sum_c, sum_q;
  logic          prod_q, vld_q, sop_q;

  csd_mul_seq #(.DATA_W(DATA_W), .PW(PW), .CW(CW)) seq_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .act_o   (act),
    .first_o (first),
    .win_o   (win),
    .msb_o   (msb),
    .cnt_o   (cnt)
  );

  // top cell at step t works at weight t+DIG_N-1
  assign inj_idx = {1'b0, cnt} + (CW + 1)'(DIG_N - 1);
  assign hi_sh   = HI_K >> inj_idx;
  assign inj     = act & hi_sh[0];

  for (genvar k = 0; k < DIG_N; k++) begin : g_cell
    if (k == DIG_N - 1) begin : g_top
      assign s_in[k] = inj;
    end else begin : g_mid
      assign s_in[k] = first ? 1'b0 : sum_q[k+1];
    end

    csd_mul_cell #(.NZ(DIG_NZ[k]), .NEG(DIG_NEG[k])) cell_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .act_i   (act),
      .first_i (first),
      .win_i   (win),
      .msb_i   (msb),
      .x_i     (x_i),
      .s_i     (s_in[k]),
      .sum_o   (sum_c[k]),
      .sum_q_o (sum_q[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= 1'b0;
      vld_q  <= 1'b0;
      sop_q  <= 1'b0;
    end else begin
      prod_q <= act & sum_c[0];
      vld_q  <= act;
      sop_q  <= first;
    end
  end

  assign prod_o     = prod_q;
  assign prod_vld_o = vld_q;
  assign prod_sop_o = sop_q;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prod_vld_o |-> !prod_o); // R1
  AST_SOP_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_sop_o |-> prod_vld_o); // R3
  AST_VLD_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prod_vld_o) |-> prod_sop_o); // R2
  AST_START_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> prod_sop_o && prod_vld_o); // R3

endmodule

// File: tb/csd_serial_mul_tb.sv
module csd_serial_mul_tb_top;

  localparam int DW = 8;
  localparam int DN = 6;
  localparam int PW = DW + DN;
  localparam int ND = 3;
  // dut 0: -1,0,+1,0,0,-1 (value -29); dut 1: top digit zero (14); dut 2: all positive (21)
  localparam logic [DN-1:0] NZS [ND] = '{6'b100101, 6'b010010, 6'b010101};
  localparam logic [DN-1:0] NGS [ND] = '{6'b100001, 6'b000010, 6'b000000};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic x_i = 1'b0;
  logic prod [ND];
  logic vld  [ND];
  logic sop  [ND];

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [PW-1:0] exp_next [ND];
  logic [PW-1:0] exp_cur  [ND];
  logic [PW-1:0] got      [ND];
  int            pos      [ND];
  string         tag_next;
  string         tag_cur  [ND];

  always #10 clk_i = ~clk_i;

  for (genvar g = 0; g < ND; g++) begin : g_dut
    csd_serial_mul #(.DATA_W(DW), .DIG_N(DN), .DIG_NZ(NZS[g]), .DIG_NEG(NGS[g])) dut_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_i),
      .x_i        (x_i),
      .prod_o     (prod[g]),
      .prod_vld_o (vld[g]),
      .prod_sop_o (sop[g])
    );
  end

  function automatic int coef_of(input logic [DN-1:0] nz, input logic [DN-1:0] ng);
    int c = 0;
    for (int k = 0; k < DN; k++) begin
      if (nz[k]) c = ng[k] ? c - (1 << k) : c + (1 << k);
    end
    return c;
  endfunction

  task automatic report_bad(input string tag, input string what, input int act, input int exp);
    n_bad++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  initial for (int g = 0; g < ND; g++) pos[g] = -1;

  // output monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      for (int g = 0; g < ND; g++) begin
        if (vld[g]) begin
          if (sop[g]) begin
            if (pos[g] >= 0) begin
              n_chk++;
              report_bad("R3", $sformatf("dut%0d sop inside word at bit", g), pos[g], 0);
            end
            pos[g]     = 0;
            exp_cur[g] = exp_next[g];
            tag_cur[g] = (g == 2 && tag_next == "R7") ? "R4" : tag_next;
          end else if (pos[g] < 0) begin
            n_chk++;
            report_bad("R2", $sformatf("dut%0d valid without open word", g), 1, 0);
          end
          if (pos[g] >= 0) begin
            got[g][pos[g]] = prod[g];
            pos[g]++;
            if (pos[g] == PW) begin
              n_chk++;
              if (got[g] !== exp_cur[g])
                report_bad(tag_cur[g], $sformatf("dut%0d product", g),
                           int'($signed(got[g])), int'($signed(exp_cur[g])));
              pos[g] = -1;
            end
          end
        end else if (pos[g] >= 0) begin
          n_chk++;
          report_bad("R2", $sformatf("dut%0d valid dropped at bit", g), pos[g], PW);
          pos[g] = -1;
        end
      end
    end
  end

  task automatic run_word(input logic [DW-1:0] x, input int gap, input string tag);
    for (int t = 0; t < gap; t++) begin
      @(negedge clk_i);
      if (t == 0) begin
        for (int g = 0; g < ND; g++)
          exp_next[g] = PW'(int'($signed(x)) * coef_of(NZS[g], NGS[g]));
        tag_next = tag;
      end
      start_i = (t == 0);
      x_i     = (t < DW) ? x[t] : 1'($urandom);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++;
      report_bad("R2", "watchdog expired at cycle", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    for (int g = 0; g < ND; g++) begin
      n_chk++;
      if ({prod[g], vld[g], sop[g]} !== 3'b000)
        report_bad("R1", $sformatf("dut%0d outputs in reset", g), int'({prod[g], vld[g], sop[g]}), 0);
    end
    rst_ni = 1'b1;
    // idle with toggling operand, no start
    for (int t = 0; t < 6; t++) begin
      @(negedge clk_i);
      x_i = 1'($urandom);
    end
    for (int g = 0; g < ND; g++) begin
      n_chk++;
      if ({prod[g], vld[g], sop[g]} !== 3'b000)
        report_bad("R1", $sformatf("dut%0d outputs while idle", g), int'({prod[g], vld[g], sop[g]}), 0);
    end
    // exhaustive sweep; a third at minimum spacing
    for (int v = 0; v < (1 << DW); v++) begin
      int    gap;
      string tag;
      gap = (v % 3 == 0) ? PW : PW + 2 + (v % 4);
      if (v == (1 << (DW - 1)))  tag = "R5";
      else if (gap == PW)        tag = "R8";
      else if (v % 2 == 1)       tag = "R6";
      else                       tag = "R7";
      run_word(DW'(v), gap, tag);
    end
    run_word(8'h80, PW, "R5");
    run_word(8'h7f, PW, "R8");
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (PW + 3) @(negedge clk_i);
    for (int g = 0; g < ND; g++) begin
      n_chk++;
      if (vld[g] !== 1'b0 || pos[g] != -1)
        report_bad("R2", $sformatf("dut%0d still valid after drain", g), int'(vld[g]), 0);
    end
    finish_run();
  end

endmodule